// File: doc/BRIEF.md
# Overlay and Color Bar Source Selector

This block chooses, pixel by pixel, the stream that goes to the back end of a composite video encoder. There are three sources. The first is the live pixel, a luminance byte and a pair of offset-binary chroma bytes that have already been split out of the 4:2:2 stream. The second is an overlay color, coded by one bit each for red, green and blue. The third is an eight-bar test pattern in luminance order, whose position in the line comes from the horizontal sample counter. The output is one luminance byte and two signed chroma bytes, registered, with a fixed latency of two clocks.

The test-bar enable has the highest priority. When it is clear, the overlay-enable pin chooses between the overlay color and live video for each pixel. Overlay and bar colors come from an eight-entry color table. They are then scaled by a 2-bit level field using shifts and adds. Live video is not scaled. Its luminance and chroma are limited to the nominal studio ranges. The bar boundaries follow the 13.5 MHz sample positions of either the 525-line or the 625-line standard.

Top module: `enc_src_sel`

## Requirements
- R1: When `bar_en` is 1, the output is the bar pattern for every value of `ovl_en` and `ovl_rgb`.
- R2: When `bar_en` is 0 and `ovl_en` is 1, the output is the scaled table color of `ovl_rgb`.
- R3: When `bar_en` and `ovl_en` are both 0, `y_out` is `live_y` limited to the range 16..235.
- R4: Live chroma is offset binary. The output is `live_cb`-128 and `live_cr`-128, each limited to -112..+112, in two's complement.
- R5: The color table is indexed by {R,G,B}, with R the MSB. At full level it gives (Y,U,V): 111 (235,0,0), 110 (210,-112,18), 011 (170,38,-112), 010 (145,-74,-94), 101 (106,74,94), 100 (81,-38,112), 001 (41,112,-18), 000 (16,0,0).
- R6: `level` 11 passes the table value unchanged. 10 gives x>>>1 plus x>>>2, 01 gives x>>>1, and 00 gives x>>>2. The shifts are arithmetic and applied to Y-16, U and V, and 16 is added back to Y.
- R7: With `pal` = 0, the bars start at samples 127, 216, 305, 394, 483, 572, 661 and 750. The sample at each start value belongs to the new bar. The bar order is white(111), yellow(110), cyan(011), green(010), magenta(101), red(100), blue(001), black(000), and black holds from the last start to the end of the line.
- R8: With `pal` = 1, the bars start at 142, 230, 318, 406, 494, 582, 670 and 757, with the same order as in R7.
- R9: When the bar pattern is selected, samples below the first start value give Y=16, U=0 and V=0 at every level.
- R10: The outputs follow the inputs sampled two rising edges earlier. While `rst` is high the outputs read Y=16, U=0, V=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hcount | input | 11 | Horizontal sample position in the line |
| pal | input | 1 | Standard select: 0 for 525-line, 1 for 625-line bar positions |
| bar_en | input | 1 | Test-bar enable |
| ovl_en | input | 1 | Overlay enable for this pixel |
| level | input | 2 | Overlay and bar level field |
| ovl_rgb | input | 3 | Overlay color {R,G,B} |
| live_y | input | 8 | Live luminance |
| live_cb | input | 8 | Live blue-difference chroma, offset binary |
| live_cr | input | 8 | Live red-difference chroma, offset binary |
| y_out | output | 8 | Selected luminance |
| u_out | output | 8 | Selected blue-difference chroma, two's complement |
| v_out | output | 8 | Selected red-difference chroma, two's complement |

## Verification
The hardest cases to reach are the single-sample bar edges. In each standard, a boundary sample and the sample before it must fall into different bars, and random values of `hcount` almost never land on both. The stimulus therefore walks every start value and its predecessor in both standards, with the bars enabled, and also while the overlay pin is toggled to confirm the override. Random mixes of source, level and color run alongside this, together with live extremes at both limits. All of it is compared with a model that applies the two-clock delay.

// File: rtl/enc_src_sel_pkg.sv
package enc_src_sel_pkg;

  typedef enum logic [1:0] {
    SRC_LIVE = 2'd0,
    SRC_OVL  = 2'd1,
    SRC_BAR  = 2'd2
  } src_t;

  typedef struct packed {
    logic        [7:0] y;
    logic signed [7:0] u;
    logic signed [7:0] v;
  } yuv_t;

  localparam int NUM_BARS = 8;

  // Start sample of bar i for the selected standard.
  function automatic int bar_start(input logic pal, input int i);
    int s;
    if (pal) s = (i == 0) ? 142 : (i == 7) ? 757 : 142 + 88 * i;
    else     s = 127 + 89 * i;
    return s;
  endfunction

  // Color code {R,G,B} of the bar at a given rank (luminance order).
  function automatic logic [2:0] bar_code(input logic [2:0] rank);
    logic [2:0] c;
    case (rank)
      3'd0: c = 3'b111;
      3'd1: c = 3'b110;
      3'd2: c = 3'b011;
      3'd3: c = 3'b010;
      3'd4: c = 3'b101;
      3'd5: c = 3'b100;
      3'd6: c = 3'b001;
      default: c = 3'b000;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/bar_locator.sv
module bar_locator
  import enc_src_sel_pkg::*;
#(
  parameter int HCW = 11
) (
  input  logic [HCW-1:0] hcount,
  input  logic           pal,
  output logic           blank,
  output logic [2:0]     code
);
  logic [NUM_BARS-1:0] past_edge;

  generate
    for (genvar i = 0; i < NUM_BARS; i++) begin : g_cmp
      assign past_edge[i] = (hcount >= HCW'(bar_start(pal, i)));
    end
  endgenerate

  logic [2:0] rank;
  assign rank  = 3'($countones(past_edge[NUM_BARS-1:1]));
  assign blank = ~past_edge[0];
  assign code  = bar_code(rank);
endmodule

// File: rtl/rgb_yuv_table.sv
module rgb_yuv_table
  import enc_src_sel_pkg::*;
(
  input  logic [2:0] code,
  output yuv_t       col
);
  always_comb begin
    case (code)
      3'b111:  col = '{y: 8'd235, u:  8'sd0,   v:  8'sd0};
      3'b110:  col = '{y: 8'd210, u: -8'sd112, v:  8'sd18};
      3'b011:  col = '{y: 8'd170, u:  8'sd38,  v: -8'sd112};
      3'b010:  col = '{y: 8'd145, u: -8'sd74,  v: -8'sd94};
      3'b101:  col = '{y: 8'd106, u:  8'sd74,  v:  8'sd94};
      3'b100:  col = '{y: 8'd81,  u: -8'sd38,  v:  8'sd112};
      3'b001:  col = '{y: 8'd41,  u:  8'sd112, v: -8'sd18};
      default: col = '{y: 8'd16,  u:  8'sd0,   v:  8'sd0};
    endcase
  end
endmodule

// File: rtl/level_scaler.sv
module level_scaler #(
  parameter int W = 9
) (
  input  logic signed [W-1:0] x,
  input  logic        [1:0]   level,
  output logic signed [W-1:0] x_scaled
);
  logic signed [W-1:0] half, quarter;
  assign half    = x >>> 1;
  assign quarter = x >>> 2;

  always_comb begin
    case (level)
      2'b11:   x_scaled = x;
      2'b10:   x_scaled = half + quarter;
      2'b01:   x_scaled = half;
      default: x_scaled = quarter;
    endcase
  end
endmodule

// File: rtl/live_limiter.sv
module live_limiter
  import enc_src_sel_pkg::*;
(
  input  logic [7:0] y_in,
  input  logic [7:0] cb_in,
  input  logic [7:0] cr_in,
  output yuv_t       lim
);
  localparam logic [7:0]        Y_LO = 8'd16;
  localparam logic [7:0]        Y_HI = 8'd235;
  localparam logic signed [7:0] C_LIM = 8'sd112;

  function automatic logic signed [7:0] clip_c(input logic [7:0] raw);
    logic signed [7:0] s;
    s = $signed(raw ^ 8'h80);
    if (s > C_LIM)       return C_LIM;
    else if (s < -C_LIM) return -C_LIM;
    else                 return s;
  endfunction

  always_comb begin
    if (y_in > Y_HI)      lim.y = Y_HI;
    else if (y_in < Y_LO) lim.y = Y_LO;
    else                  lim.y = y_in;
    lim.u = clip_c(cb_in);
    lim.v = clip_c(cr_in);
  end
endmodule

// File: rtl/enc_src_sel.sv
module enc_src_sel
  import enc_src_sel_pkg::*;
#(
  parameter int HCW = 11,
  parameter int NCH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HCW-1:0] hcount,
  input  logic           pal,
  input  logic           bar_en,
  input  logic           ovl_en,
  input  logic [1:0]     level,
  input  logic [2:0]     ovl_rgb,
  input  logic [7:0]     live_y,
  input  logic [7:0]     live_cb,
  input  logic [7:0]     live_cr,
  output logic [7:0]     y_out,
  output logic [7:0]     u_out,
  output logic [7:0]     v_out
);
  localparam int SW = 9;
  localparam logic signed [SW-1:0] BLACK_OFS = SW'(16);

  // Stage 1: source decision, bar decode and live limiting.
  logic       bar_blank;
  logic [2:0] bar_cd;
  yuv_t       live_lim;

  bar_locator #(.HCW(HCW)) u_loc (
    .hcount (hcount),
    .pal    (pal),
    .blank  (bar_blank),
    .code   (bar_cd)
  );

  live_limiter u_lim (
    .y_in  (live_y),
    .cb_in (live_cb),
    .cr_in (live_cr),
    .lim   (live_lim)
  );

  src_t       s1_src;
  logic [2:0] s1_code;
  logic       s1_blank;
  logic [1:0] s1_level;
  yuv_t       s1_live;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_src   <= SRC_LIVE;
      s1_code  <= 3'b000;
      s1_blank <= 1'b0;
      s1_level <= 2'b11;
      s1_live  <= '{y: 8'd16, u: 8'sd0, v: 8'sd0};
    end else begin
      s1_level <= level;
      s1_live  <= live_lim;
      if (bar_en) begin
        s1_src   <= SRC_BAR;
        s1_code  <= bar_cd;
        s1_blank <= bar_blank;
      end else if (ovl_en) begin
        s1_src   <= SRC_OVL;
        s1_code  <= ovl_rgb;
        s1_blank <= 1'b0;
      end else begin
        s1_src   <= SRC_LIVE;
        s1_code  <= ovl_rgb;
        s1_blank <= 1'b0;
      end
    end
  end

  // Stage 2: table lookup, level scaling, final select.
  yuv_t base;
  rgb_yuv_table u_tab (
    .code (s1_code),
    .col  (base)
  );

  logic signed [SW-1:0] ch_in  [NCH];
  logic signed [SW-1:0] ch_out [NCH];

  assign ch_in[0] = $signed({1'b0, base.y}) - BLACK_OFS;
  assign ch_in[1] = {base.u[7], base.u};
  assign ch_in[2] = {base.v[7], base.v};

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_scale
      level_scaler #(.W(SW)) u_sc (
        .x        (ch_in[c]),
        .level    (s1_level),
        .x_scaled (ch_out[c])
      );
    end
  endgenerate

  logic signed [SW-1:0] y_sum;
  assign y_sum = ch_out[0] + BLACK_OFS;

  yuv_t gen_pix, nxt_pix;
  always_comb begin
    gen_pix.y = y_sum[7:0];
    gen_pix.u = ch_out[1][7:0];
    gen_pix.v = ch_out[2][7:0];
    case (s1_src)
      SRC_BAR:  nxt_pix = s1_blank ? '{y: 8'd16, u: 8'sd0, v: 8'sd0} : gen_pix;
      SRC_OVL:  nxt_pix = gen_pix;
      default:  nxt_pix = s1_live;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out <= 8'd16;
      u_out <= 8'd0;
      v_out <= 8'd0;
    end else begin
      y_out <= nxt_pix.y;
      u_out <= nxt_pix.u;
      v_out <= nxt_pix.v;
    end
  end
endmodule

// File: rtl/enc_src_sel_chk.sv
module enc_src_sel_chk #(
  parameter int HCW = 11
) (
  input logic           clk,
  input logic           rst,
  input logic [HCW-1:0] hcount,
  input logic           pal,
  input logic           bar_en,
  input logic           ovl_en,
  input logic [1:0]     level,
  input logic [2:0]     ovl_rgb,
  input logic [7:0]     y_out,
  input logic [7:0]     u_out,
  input logic [7:0]     v_out
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= 2'd0;
    else if (age != 3)  age <= age + 2'd1;
  end

  logic in_blank;
  assign in_blank = bar_en && (hcount < (pal ? HCW'(142) : HCW'(127)));

  // R10
  reset_black_chk: assert property (@(posedge clk) rst |=> (y_out == 8'd16 && u_out == 8'd0 && v_out == 8'd0));

  // R3
  luma_range_chk: assert property (@(posedge clk) disable iff (rst)
    age >= 2'd2 |-> (y_out >= 8'd16 && y_out <= 8'd235));

  // R4
  chroma_range_chk: assert property (@(posedge clk) disable iff (rst)
    age >= 2'd2 |-> ($signed(u_out) >= -8'sd112 && $signed(u_out) <= 8'sd112 &&
                     $signed(v_out) >= -8'sd112 && $signed(v_out) <= 8'sd112));

  // R9
  bar_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(in_blank, 2)) |-> (y_out == 8'd16 && u_out == 8'd0 && v_out == 8'd0));

  // R2
  ovl_white_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(!bar_en && ovl_en && level == 2'b11 && ovl_rgb == 3'b111, 2))
      |-> (y_out == 8'd235 && u_out == 8'd0 && v_out == 8'd0));

  // R1
  bar_first_white_chk: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2 && $past(bar_en && level == 2'b11 && !pal && hcount == HCW'(127), 2))
      |-> (y_out == 8'd235));
endmodule

bind enc_src_sel enc_src_sel_chk #(.HCW(HCW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hcount  (hcount),
  .pal     (pal),
  .bar_en  (bar_en),
  .ovl_en  (ovl_en),
  .level   (level),
  .ovl_rgb (ovl_rgb),
  .y_out   (y_out),
  .u_out   (u_out),
  .v_out   (v_out)
);

// File: tb/enc_src_sel_tb.sv
module enc_src_sel_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [10:0] hcount;
  logic        pal, bar_en, ovl_en;
  logic [1:0]  level;
  logic [2:0]  ovl_rgb;
  logic [7:0]  live_y, live_cb, live_cr;
  logic [7:0]  y_out, u_out, v_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  enc_src_sel u_dut (
    .clk(clk), .rst(rst), .hcount(hcount), .pal(pal), .bar_en(bar_en),
    .ovl_en(ovl_en), .level(level), .ovl_rgb(ovl_rgb), .live_y(live_y),
    .live_cb(live_cb), .live_cr(live_cr), .y_out(y_out), .u_out(u_out), .v_out(v_out)
  );

  // Expected pipeline: e1 = driven last negedge, e2 = two negedges ago.
  int    e1_y, e1_u, e1_v, e2_y, e2_u, e2_v;
  bit    e1_ok = 0, e2_ok = 0;
  string e1_tag, e2_tag;

  function automatic int nom_start(bit p, int i);
    int n [8] = '{127, 216, 305, 394, 483, 572, 661, 750};
    int q [8] = '{142, 230, 318, 406, 494, 582, 670, 757};
    return p ? q[i] : n[i];
  endfunction

  function automatic void color100(int code, output int y, output int u, output int v);
    case (code)
      7: begin y = 235; u = 0;    v = 0;    end
      6: begin y = 210; u = -112; v = 18;   end
      3: begin y = 170; u = 38;   v = -112; end
      2: begin y = 145; u = -74;  v = -94;  end
      5: begin y = 106; u = 74;   v = 94;   end
      4: begin y = 81;  u = -38;  v = 112;  end
      1: begin y = 41;  u = 112;  v = -18;  end
      default: begin y = 16; u = 0; v = 0; end
    endcase
  endfunction

  function automatic int lvl_scale(int x, int l);
    case (l)
      3: return x;
      2: return (x >>> 1) + (x >>> 2);
      1: return x >>> 1;
      default: return x >>> 2;
    endcase
  endfunction

  function automatic int lim(int x, int lo, int hi);
    return (x < lo) ? lo : (x > hi) ? hi : x;
  endfunction

  function automatic void model(bit be, bit oe, bit p, int h, int l, int rgb,
                                int ly, int lcb, int lcr,
                                output int y, output int u, output int v);
    int order [8] = '{7, 6, 3, 2, 5, 4, 1, 0};
    int code, ty, tu, tv, rank;
    if (!be && !oe) begin
      y = lim(ly, 16, 235);
      u = lim(lcb - 128, -112, 112);
      v = lim(lcr - 128, -112, 112);
      return;
    end
    if (be) begin
      if (h < nom_start(p, 0)) begin y = 16; u = 0; v = 0; return; end
      rank = 0;
      for (int i = 1; i < 8; i++) if (h >= nom_start(p, i)) rank = i;
      code = order[rank];
    end else code = rgb;
    color100(code, ty, tu, tv);
    y = 16 + lvl_scale(ty - 16, l);
    u = lvl_scale(tu, l);
    v = lvl_scale(tv, l);
  endfunction

  task automatic check_now();
    int ay, au, av;
    if (!e2_ok) return;
    ay = int'(y_out); au = int'($signed(u_out)); av = int'($signed(v_out));
    checks++;
    // R10: comparison made two cycles after the inputs were applied
    if (ay != e2_y || au != e2_u || av != e2_v) begin
      errors++;
      $display("FAIL %s: got Y=%0d U=%0d V=%0d expected Y=%0d U=%0d V=%0d",
               e2_tag, ay, au, av, e2_y, e2_u, e2_v);
    end
  endtask

  task automatic drive(bit be, bit oe, bit p, int h, int l, int rgb, int ly, int lcb, int lcr);
    int y, u, v;
    @(negedge clk);
    check_now();
    e2_y = e1_y; e2_u = e1_u; e2_v = e1_v; e2_ok = e1_ok; e2_tag = e1_tag;
    bar_en = be; ovl_en = oe; pal = p; hcount = 11'(h); level = 2'(l);
    ovl_rgb = 3'(rgb); live_y = 8'(ly); live_cb = 8'(lcb); live_cr = 8'(lcr);
    model(be, oe, p, h, l, rgb, ly, lcb, lcr, y, u, v);
    e1_y = y; e1_u = u; e1_v = v; e1_ok = 1;
    if (be && h < nom_start(p, 0))  e1_tag = "R9 blank";
    else if (be && oe)              e1_tag = "R1 bar override";
    else if (be)                    e1_tag = p ? "R8 625 bars" : "R7 525 bars";
    else if (oe)                    e1_tag = (l != 3) ? "R6 level" : "R2/R5 overlay";
    else                            e1_tag = "R3/R4 live";
  endtask

  task automatic flush();
    repeat (2) drive(0, 0, 0, 0, 3, 0, 128, 128, 128);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int r;
    rst = 1; bar_en = 1; ovl_en = 1; pal = 0; hcount = 11'd300; level = 2'd0;
    ovl_rgb = 3'd6; live_y = 8'd0; live_cb = 8'd0; live_cr = 8'd0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    checks++;
    if (y_out != 8'd16 || u_out != 8'd0 || v_out != 8'd0) begin
      errors++;
      $display("FAIL R10 reset: got Y=%0d U=%0d V=%0d expected Y=16 U=0 V=0", y_out, u_out, v_out);
    end
    rst = 0;

    // R7 / R8: each bar start and its predecessor, both standards, overlay pin toggled (R1)
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 8; i++) begin
        drive(1, 0, p[0], nom_start(p[0], i) - 1, 3, 0, 50, 50, 50);
        drive(1, 1, p[0], nom_start(p[0], i), 3, 6, 50, 50, 50);
      end
    drive(1, 0, 0, 857, 3, 0, 0, 0, 0);   // R7 end of line black
    drive(1, 1, 1, 0, 0, 7, 0, 0, 0);     // R9 blank at 25% level

    // R2 / R5 / R6: every color at every level
    for (int l = 0; l < 4; l++)
      for (int c = 0; c < 8; c++) drive(0, 1, 0, 500, l, c, 200, 10, 240);

    // R3 / R4: live limits
    drive(0, 0, 0, 10, 3, 7, 0, 0, 255);
    drive(0, 0, 0, 10, 3, 7, 255, 255, 0);
    drive(0, 0, 1, 10, 0, 7, 16, 16, 240);
    drive(0, 0, 1, 10, 0, 7, 235, 240, 16);
    drive(0, 0, 1, 10, 0, 7, 15, 15, 241);

    // Random mix
    r = $urandom(32'h1ac7);
    for (int n = 0; n < 4000; n++) begin
      r = $urandom;
      drive((r & 3) == 0, r[2], r[3], int'($urandom % 900), int'(r[5:4]), int'(r[8:6]),
            int'($urandom % 256), int'($urandom % 256), int'($urandom % 256));
    end
    flush();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule